// File: doc/BRIEF.md
# Banked Instruction Decoder for a Character Display Controller

This block sits between a host write port and the rest of a character display controller. It accepts 8-bit instruction writes, sorts each one into an opcode class and keeps the controller's mode registers. It also issues one-cycle strobes toward the address counter and toward the clear, home and shift logic. The class of an instruction is set by the position of its highest set bit. A write is an instruction only while the register-select line is low.

A two-state bank machine decides which register set some opcodes reach. In `BANK_BASE` (the reset state) the two address-set classes load a character-generator address or a display address. The function-set class changes only the bus width and line count. The OPEN transition moves to `BANK_EXT` when a function set arrives with its bank bit set. The CLOSE transition moves back when a function set arrives with that bit clear. In every other cycle the HOLD transition keeps the current state. In `BANK_EXT` the function set also writes the blink-enable and low-power bits. The highest class loads a segment address together with a 3-bit field, and the display-control class writes the extended function register. Character-generator address loads and entry-mode writes are dropped in this bank.

Low-power mode is in force when the low-power bit is set and no external driver is present. In that mode the block reports a clock divide ratio of 4 for one-line displays and 2 for multi-line displays, and it refuses whole-display shifts.

Top module: `lcdi_decoder`

## Requirements
- R1: After reset, ext_en, blink_en, lp_bit, every mode output, ac_val and hs_field are 0, every strobe is low and div_ratio is 1.
- R2: A write is decoded only when wr_stb is 1 and rs is 0. A write with rs=1 changes no output.
- R3: A function set (binary 001xxxxx) sets ext_en to din[2] in either bank. ext_en changes on no other write.
- R4: blink_en takes din[1] and lp_bit takes din[0] from a function set only when ext_en was 1 before that write. Otherwise both keep their value. The write that opens the bank therefore does not change them, and the write that closes the bank does.
- R5: In the base bank, 01AAAAAA pulses ld_cg with ac_val = {0, AAAAAA}. In the extended bank this instruction is ignored.
- R6: 1xxxxxxx in the base bank pulses ld_dd with ac_val = din[6:0]. In the extended bank it pulses ld_seg with ac_val = din[3:0] and loads hs_field = din[6:4]. hs_field is otherwise held.
- R7: 00001xxx in the base bank writes disp_on=din[2], cur_on=din[1], cur_blink=din[0]. In the extended bank it writes wide_font=din[2] and four_line=din[0]. The other bank's fields are kept.
- R8: lp_active = lp_bit AND NOT ext_drv. div_ratio is 1 when lp_active is low, 4 when lp_active is high and both two_line and four_line are 0, and 2 otherwise.
- R9: 0001SRxx pulses shift_stb and loads shift_disp=S (din[3]) and shift_right=R (din[2]). When S=1 while lp_active is high, the instruction is ignored.
- R10: 000001IS in the base bank writes entry_inc=I and entry_shift=S. In the extended bank it is ignored.
- R11: 00000010 (class of bit 1) pulses home_stb and 00000001 pulses clear_stb in either bank. 00000000 does nothing.
- R12: Every function set pulses func_stb and writes bus8=din[4] and two_line=din[3].
- R13: Every strobe is high for exactly the one cycle after the accepted write and is low in the following cycle unless another write triggers it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_stb | input | 1 | Host write strobe, one cycle per write |
| rs | input | 1 | Register select, 0 marks an instruction |
| din | input | 8 | Instruction byte |
| ext_drv | input | 1 | High when an external driver is fitted |
| ext_en | output | 1 | Extended bank open |
| bus8 | output | 1 | 8-bit host bus selected |
| two_line | output | 1 | Two-line display mode |
| four_line | output | 1 | Four-line display mode |
| wide_font | output | 1 | Wide font selected |
| blink_en | output | 1 | User-font and segment blink enable |
| lp_bit | output | 1 | Low-power request bit |
| lp_active | output | 1 | Low-power mode in force |
| div_ratio | output | 3 | Internal clock divide ratio (1, 2 or 4) |
| disp_on | output | 1 | Display on |
| cur_on | output | 1 | Cursor on |
| cur_blink | output | 1 | Cursor blink |
| entry_inc | output | 1 | Address increments after a transfer |
| entry_shift | output | 1 | Display shifts on a transfer |
| func_stb | output | 1 | Function set accepted |
| clear_stb | output | 1 | Clear display accepted |
| home_stb | output | 1 | Return home accepted |
| shift_stb | output | 1 | Cursor or display shift accepted |
| shift_disp | output | 1 | Last shift moves the display |
| shift_right | output | 1 | Last shift is to the right |
| ld_dd | output | 1 | Load display address into address counter |
| ld_cg | output | 1 | Load character-generator address |
| ld_seg | output | 1 | Load segment address |
| ac_val | output | 7 | Address value for the load strobes |
| hs_field | output | 3 | 3-bit field loaded with a segment address |

## Verification
A wrong bank state shows up on the first address-set or function-set write after it. The same opcode then raises ld_dd instead of ld_seg, or ld_cg when it should be dropped, one cycle after the write. Blink-enable and low-power bits that are written or kept wrongly show up at once on lp_active and div_ratio, and one instruction later as an accepted or refused display shift. Because the reference model is compared on every clock, a stray or stretched strobe is caught in the cycle it appears.

// File: rtl/lcdi_pkg.sv
package lcdi_pkg;

    typedef enum logic {
        BANK_BASE = 1'b0,
        BANK_EXT  = 1'b1
    } bank_e;

    typedef enum logic [3:0] {
        OP_NOP,
        OP_CLEAR,
        OP_HOME,
        OP_ENTRY,
        OP_DISP,
        OP_SHIFT,
        OP_FUNC,
        OP_CGADR,
        OP_DDADR
    } op_e;

endpackage

// File: rtl/lcdi_opclass.sv
module lcdi_opclass
    import lcdi_pkg::*;
#(
    parameter int W = 8
) (
    input  logic [W-1:0] insn,
    output op_e          op
);
    localparam int IW = $clog2(W);

    logic [IW-1:0] msb;
    logic          any;

    // highest set bit wins
    always_comb begin
        msb = '0;
        any = 1'b0;
        for (int i = 0; i < W; i++) begin
            if (insn[i]) begin
                msb = IW'(i);
                any = 1'b1;
            end
        end
    end

    always_comb begin
        op = OP_NOP;
        if (any) begin
            case (int'(msb))
                W-1:     op = OP_DDADR;
                W-2:     op = OP_CGADR;
                W-3:     op = OP_FUNC;
                W-4:     op = OP_SHIFT;
                W-5:     op = OP_DISP;
                W-6:     op = OP_ENTRY;
                W-7:     op = OP_HOME;
                W-8:     op = OP_CLEAR;
                default: op = OP_NOP;
            endcase
        end
    end
endmodule

// File: rtl/lcdi_bank_fsm.sv
module lcdi_bank_fsm
    import lcdi_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic func_wr,
    input  logic bank_bit,
    output logic ext_en
);
    bank_e state, state_nx;

    always_comb begin
        state_nx = state;
        unique case (state)
            BANK_BASE: if (func_wr && bank_bit)  state_nx = BANK_EXT;   // OPEN
            BANK_EXT:  if (func_wr && !bank_bit) state_nx = BANK_BASE;  // CLOSE
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= BANK_BASE;
        else        state <= state_nx;
    end

    always_comb begin
        unique case (state)
            BANK_BASE: ext_en = 1'b0;
            BANK_EXT:  ext_en = 1'b1;
        endcase
    end

    AST_BANK_OPEN: assert property (@(posedge clk) disable iff (!rst_n)
        (func_wr && bank_bit) |=> ext_en);            // R3
    AST_BANK_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
        !func_wr |=> $stable(ext_en));                // R3
endmodule

// File: rtl/lcdi_clkdiv.sv
module lcdi_clkdiv #(
    parameter int DIV_W      = 3,
    parameter int DIV_SINGLE = 4,
    parameter int DIV_MULTI  = 2
) (
    input  logic             lp_bit,
    input  logic             ext_drv,
    input  logic             two_line,
    input  logic             four_line,
    output logic             lp_active,
    output logic [DIV_W-1:0] div_ratio
);
    always_comb begin
        lp_active = lp_bit && !ext_drv;
        if (!lp_active)                 div_ratio = DIV_W'(1);
        else if (two_line || four_line) div_ratio = DIV_W'(DIV_MULTI);
        else                            div_ratio = DIV_W'(DIV_SINGLE);
    end
endmodule

// File: rtl/lcdi_modereg.sv
module lcdi_modereg
    import lcdi_pkg::*;
#(
    parameter int DD_AW  = 7,
    parameter int CG_AW  = 6,
    parameter int SEG_AW = 4,
    parameter int HS_W   = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             acc,
    input  op_e              op,
    input  logic [DD_AW-1:0] insn,
    input  logic             ext_en,
    input  logic             lp_active,
    output logic             bus8,
    output logic             two_line,
    output logic             four_line,
    output logic             wide_font,
    output logic             blink_en,
    output logic             lp_bit,
    output logic             disp_on,
    output logic             cur_on,
    output logic             cur_blink,
    output logic             entry_inc,
    output logic             entry_shift,
    output logic             func_stb,
    output logic             clear_stb,
    output logic             home_stb,
    output logic             shift_stb,
    output logic             shift_disp,
    output logic             shift_right,
    output logic             ld_dd,
    output logic             ld_cg,
    output logic             ld_seg,
    output logic [DD_AW-1:0] ac_val,
    output logic [HS_W-1:0]  hs_field
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bus8 <= 1'b0;      two_line <= 1'b0;    four_line <= 1'b0;
            wide_font <= 1'b0; blink_en <= 1'b0;    lp_bit <= 1'b0;
            disp_on <= 1'b0;   cur_on <= 1'b0;      cur_blink <= 1'b0;
            entry_inc <= 1'b0; entry_shift <= 1'b0;
            func_stb <= 1'b0;  clear_stb <= 1'b0;   home_stb <= 1'b0;
            shift_stb <= 1'b0; shift_disp <= 1'b0;  shift_right <= 1'b0;
            ld_dd <= 1'b0;     ld_cg <= 1'b0;       ld_seg <= 1'b0;
            ac_val <= '0;      hs_field <= '0;
        end else begin
            func_stb  <= 1'b0;
            clear_stb <= 1'b0;
            home_stb  <= 1'b0;
            shift_stb <= 1'b0;
            ld_dd     <= 1'b0;
            ld_cg     <= 1'b0;
            ld_seg    <= 1'b0;
            if (acc) begin
                unique case (op)
                    OP_CLEAR: clear_stb <= 1'b1;
                    OP_HOME:  home_stb  <= 1'b1;
                    OP_ENTRY: if (!ext_en) begin
                        entry_inc   <= insn[1];
                        entry_shift <= insn[0];
                    end
                    OP_DISP: if (ext_en) begin
                        wide_font <= insn[2];
                        four_line <= insn[0];
                    end else begin
                        disp_on   <= insn[2];
                        cur_on    <= insn[1];
                        cur_blink <= insn[0];
                    end
                    OP_SHIFT: if (!(insn[3] && lp_active)) begin
                        shift_stb   <= 1'b1;
                        shift_disp  <= insn[3];
                        shift_right <= insn[2];
                    end
                    OP_FUNC: begin
                        func_stb <= 1'b1;
                        bus8     <= insn[4];
                        two_line <= insn[3];
                        if (ext_en) begin
                            blink_en <= insn[1];
                            lp_bit   <= insn[0];
                        end
                    end
                    OP_CGADR: if (!ext_en) begin
                        ld_cg  <= 1'b1;
                        ac_val <= DD_AW'(insn[CG_AW-1:0]);
                    end
                    OP_DDADR: if (ext_en) begin
                        ld_seg   <= 1'b1;
                        ac_val   <= DD_AW'(insn[SEG_AW-1:0]);
                        hs_field <= insn[SEG_AW+HS_W-1:SEG_AW];
                    end else begin
                        ld_dd  <= 1'b1;
                        ac_val <= insn;
                    end
                    default: ;
                endcase
            end
        end
    end

    AST_BANK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !ext_en |=> ($stable(blink_en) && $stable(lp_bit)));   // R4
    AST_CG_BASE: assert property (@(posedge clk) disable iff (!rst_n)
        ld_cg |-> !$past(ext_en));                             // R5
    AST_SEG_EXT: assert property (@(posedge clk) disable iff (!rst_n)
        ld_seg |-> $past(ext_en));                             // R6
endmodule

// File: rtl/lcdi_decoder.sv
module lcdi_decoder
    import lcdi_pkg::*;
#(
    parameter int DD_AW  = 7,
    parameter int CG_AW  = 6,
    parameter int SEG_AW = 4,
    parameter int HS_W   = 3,
    parameter int DIV_W  = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_stb,
    input  logic             rs,
    input  logic [DD_AW:0]   din,
    input  logic             ext_drv,
    output logic             ext_en,
    output logic             bus8,
    output logic             two_line,
    output logic             four_line,
    output logic             wide_font,
    output logic             blink_en,
    output logic             lp_bit,
    output logic             lp_active,
    output logic [DIV_W-1:0] div_ratio,
    output logic             disp_on,
    output logic             cur_on,
    output logic             cur_blink,
    output logic             entry_inc,
    output logic             entry_shift,
    output logic             func_stb,
    output logic             clear_stb,
    output logic             home_stb,
    output logic             shift_stb,
    output logic             shift_disp,
    output logic             shift_right,
    output logic             ld_dd,
    output logic             ld_cg,
    output logic             ld_seg,
    output logic [DD_AW-1:0] ac_val,
    output logic [HS_W-1:0]  hs_field
);
    localparam int INSN_W = DD_AW + 1;

    op_e  op;
    logic acc;

    assign acc = wr_stb && !rs;

    lcdi_opclass #(.W(INSN_W)) u_cls (
        .insn (din),
        .op   (op)
    );

    lcdi_bank_fsm u_bank (
        .clk      (clk),
        .rst_n    (rst_n),
        .func_wr  (acc && (op == OP_FUNC)),
        .bank_bit (din[2]),
        .ext_en   (ext_en)
    );

    lcdi_clkdiv #(.DIV_W(DIV_W)) u_div (
        .lp_bit    (lp_bit),
        .ext_drv   (ext_drv),
        .two_line  (two_line),
        .four_line (four_line),
        .lp_active (lp_active),
        .div_ratio (div_ratio)
    );

    lcdi_modereg #(
        .DD_AW(DD_AW), .CG_AW(CG_AW), .SEG_AW(SEG_AW), .HS_W(HS_W)
    ) u_regs (
        .clk         (clk),
        .rst_n       (rst_n),
        .acc         (acc),
        .op          (op),
        .insn        (din[DD_AW-1:0]),
        .ext_en      (ext_en),
        .lp_active   (lp_active),
        .bus8        (bus8),
        .two_line    (two_line),
        .four_line   (four_line),
        .wide_font   (wide_font),
        .blink_en    (blink_en),
        .lp_bit      (lp_bit),
        .disp_on     (disp_on),
        .cur_on      (cur_on),
        .cur_blink   (cur_blink),
        .entry_inc   (entry_inc),
        .entry_shift (entry_shift),
        .func_stb    (func_stb),
        .clear_stb   (clear_stb),
        .home_stb    (home_stb),
        .shift_stb   (shift_stb),
        .shift_disp  (shift_disp),
        .shift_right (shift_right),
        .ld_dd       (ld_dd),
        .ld_cg       (ld_cg),
        .ld_seg      (ld_seg),
        .ac_val      (ac_val),
        .hs_field    (hs_field)
    );

    AST_RS_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_stb && rs) |=> !(func_stb || clear_stb || home_stb || shift_stb
                             || ld_dd || ld_cg || ld_seg));      // R2
    AST_EXTDRV_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        ext_drv |-> (div_ratio == DIV_W'(1)));                   // R8
endmodule

// File: tb/sim_lcdi_decoder.sv
module sim_lcdi_decoder;
    localparam int CLK_PER = 10;
    localparam int WDOG    = 5000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic wr_stb = 1'b0, rs = 1'b0, ext_drv = 1'b0;
    logic [7:0] din = 8'h00;
    logic ext_en, bus8, two_line, four_line, wide_font, blink_en, lp_bit, lp_active;
    logic [2:0] div_ratio;
    logic disp_on, cur_on, cur_blink, entry_inc, entry_shift;
    logic func_stb, clear_stb, home_stb, shift_stb, shift_disp, shift_right;
    logic ld_dd, ld_cg, ld_seg;
    logic [6:0] ac_val;
    logic [2:0] hs_field;

    int n_chk = 0, n_fail = 0;
    bit done = 0;

    // reference model state
    bit m_ext, m_bus8, m_two, m_four, m_wide, m_blink, m_lp;
    bit m_disp, m_cur, m_cblink, m_inc, m_eshift, m_sdisp, m_sright;
    bit e_func, e_clear, e_home, e_shift, e_dd, e_cg, e_seg;
    int m_ac, m_hs;

    always #(CLK_PER/2) clk = ~clk;

    lcdi_decoder u0 (.*);

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
        end
    endtask

    task automatic compare_all();
        bit lpa;
        int dv;
        lpa = m_lp && !ext_drv;
        dv  = !lpa ? 1 : ((m_two || m_four) ? 2 : 4);
        chk("R3 ext_en", ext_en, m_ext);
        chk("R12 bus8", bus8, m_bus8);
        chk("R12 two_line", two_line, m_two);
        chk("R7 four_line", four_line, m_four);
        chk("R7 wide_font", wide_font, m_wide);
        chk("R4 blink_en", blink_en, m_blink);
        chk("R4 lp_bit", lp_bit, m_lp);
        chk("R8 lp_active", lp_active, lpa);
        chk("R8 div_ratio", div_ratio, dv);
        chk("R7 disp_on", disp_on, m_disp);
        chk("R7 cur_on", cur_on, m_cur);
        chk("R7 cur_blink", cur_blink, m_cblink);
        chk("R10 entry_inc", entry_inc, m_inc);
        chk("R10 entry_shift", entry_shift, m_eshift);
        chk("R12 func_stb", func_stb, e_func);
        chk("R11 clear_stb", clear_stb, e_clear);
        chk("R11 home_stb", home_stb, e_home);
        chk("R9 shift_stb", shift_stb, e_shift);
        chk("R9 shift_disp", shift_disp, m_sdisp);
        chk("R9 shift_right", shift_right, m_sright);
        chk("R6 ld_dd", ld_dd, e_dd);
        chk("R5 ld_cg", ld_cg, e_cg);
        chk("R6 ld_seg", ld_seg, e_seg);
        chk("R6 ac_val", ac_val, m_ac);
        chk("R6 hs_field", hs_field, m_hs);
    endtask

    // one clock: drive, advance model, compare after the edge
    task automatic step(input bit w, input bit r, input logic [7:0] d);
        bit lpa;
        wr_stb = w; rs = r; din = d;
        lpa = m_lp && !ext_drv;
        {e_func, e_clear, e_home, e_shift, e_dd, e_cg, e_seg} = '0;
        if (w && !r) begin
            if (d[7]) begin
                if (m_ext) begin e_seg = 1; m_ac = int'(d[3:0]); m_hs = int'(d[6:4]); end
                else begin e_dd = 1; m_ac = int'(d[6:0]); end
            end else if (d[6]) begin
                if (!m_ext) begin e_cg = 1; m_ac = int'(d[5:0]); end
            end else if (d[5]) begin
                e_func = 1; m_bus8 = d[4]; m_two = d[3];
                if (m_ext) begin m_blink = d[1]; m_lp = d[0]; end
                m_ext = d[2];
            end else if (d[4]) begin
                if (!(d[3] && lpa)) begin e_shift = 1; m_sdisp = d[3]; m_sright = d[2]; end
            end else if (d[3]) begin
                if (m_ext) begin m_wide = d[2]; m_four = d[0]; end
                else begin m_disp = d[2]; m_cur = d[1]; m_cblink = d[0]; end
            end else if (d[2]) begin
                if (!m_ext) begin m_inc = d[1]; m_eshift = d[0]; end
            end else if (d[1]) e_home = 1;
            else if (d[0]) e_clear = 1;
        end
        @(posedge clk);
        #1;
        compare_all();
    endtask

    task automatic wr(input logic [7:0] d);
        step(1, 0, d);
    endtask

    task automatic idle();
        step(0, 0, 8'h00);
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    endtask

    initial begin
        repeat (WDOG) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog act=%0d exp=%0d", WDOG, 0);
            summary();
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        // R1: reset state
        chk("R1 ext_en", ext_en, 0);
        chk("R1 blink_en", blink_en, 0);
        chk("R1 lp_bit", lp_bit, 0);
        chk("R1 div_ratio", div_ratio, 1);
        chk("R1 strobes", {func_stb, clear_stb, home_stb, shift_stb, ld_dd, ld_cg, ld_seg}, 0);
        chk("R1 ac_val", ac_val, 0);
        @(negedge clk);
        rst_n = 1'b1;
        idle();

        // R2: data write (rs=1) is not an instruction
        step(1, 1, 8'h2F);
        chk("R2 rs write ignored ext_en", ext_en, 0);
        chk("R2 rs write no strobe", func_stb, 0);

        // base bank
        wr(8'h3B);          // 8-bit, two-line, BE/LP bits ignored (R4)
        wr(8'h6A);          // CG address 0x2A (R5)
        idle();
        chk("R13 ld_cg single cycle", ld_cg, 0);
        wr(8'hC5);          // display address 0x45 (R6)
        wr(8'hFF);          // display address 0x7F
        wr(8'h0F);          // display/cursor/blink on (R7)
        wr(8'h06);          // entry increment (R10)
        wr(8'h1C);          // display shift right (R9)
        wr(8'h02);          // home (R11)
        wr(8'h01);          // clear (R11)
        wr(8'h00);          // nothing (R11)
        idle();

        // open bank with BE/LP set: not written yet (R4)
        wr(8'h27);
        chk("R4 open write keeps blink", blink_en, 0);
        wr(8'h55);          // CG set dropped in extended bank (R5)
        chk("R5 cg ignored in ext", ld_cg, 0);
        wr(8'hB9);          // segment address 9, field 3 (R6)
        wr(8'h27);          // BE=1, LP=1, one-line -> divide by 4 (R8)
        chk("R8 one-line low power", div_ratio, 4);
        wr(8'h18);          // display shift refused in low power (R9)
        chk("R9 display shift refused", shift_stb, 0);
        wr(8'h14);          // cursor shift right accepted
        wr(8'h0D);          // wide font, four-line -> divide by 2 (R7, R8)
        wr(8'h05);          // entry mode dropped (R10)
        wr(8'hEA);          // second segment load, field 6
        ext_drv = 1'b1;     // external driver: low power off (R8)
        idle();
        wr(8'h1C);          // display shift now accepted
        wr(8'h2C);          // clear BE/LP while still in bank
        ext_drv = 1'b0;
        wr(8'h27);          // set them again
        wr(8'h23);          // close bank: BE/LP written from this write (R4)
        wr(8'h30);          // base function set keeps BE/LP
        chk("R4 base keeps lp_bit", lp_bit, 1);
        wr(8'h41);          // CG load works again (R5)
        wr(8'h81);          // display load again (R6)
        repeat (3) idle();
        chk("R13 strobes quiet", {func_stb, ld_dd, ld_cg, ld_seg, shift_stb}, 0);

        done = 1;
        summary();
        $finish;
    end
endmodule